// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a 12-bit voltage-output converter. A host writes 16-bit words over a three-wire serial link: a clock (`sclk`), an active-low select (`cs_n`) and a data line (`din`). Each word carries a 3-bit command, a 12-bit data field and a trailing sub-bit. The block keeps two 12-bit code registers. The staging register (`in_code`) can be written without changing the analog output. The converter register (`dac_code`) is the code that drives the analog core. Some commands move the staged code across, and one command writes both registers at once.

Other commands set a general-purpose logic output, choose the serial clock edge on which the echo line `dout` launches its bits, and put the converter into power-down. Entering and leaving power-down are reported to an external power controller as one-cycle request pulses. The serial pins are brought into a faster system clock through synchronizers and edge detectors, so all of the logic runs in a single clock domain. The serial clock must be slow enough that each phase lasts several system clock cycles.

Top module: `sdac_cmd_if`

## Requirements
- R1: After reset, `in_code` and `dac_code` are 0, and `user_out`, `dout_rise`, `pd_state`, `dout_oe`, `shdn_req` and `wake_req` are all 0.
- R2: While `cs_n` is low, a bit is taken from `din` on each rising `sclk` edge, MSB first, in this order: command bits [2:0], then data D11 down to D0, then the sub-bit. The rising edge of `cs_n` executes the word.
- R3: A word runs only if exactly 16 rising `sclk` edges were seen while `cs_n` was low. Shorter or longer words change no register. `sclk` edges while `cs_n` is high are not counted.
- R4: Command 001 writes the data field into `in_code` and leaves `dac_code` unchanged.
- R5: Command 010 copies `in_code` into `dac_code`, clears `pd_state` and pulses `wake_req`.
- R6: Command 011 writes the data field into both `in_code` and `dac_code`, clears `pd_state` and pulses `wake_req`.
- R7: Command 100 drives `user_out` low. Command 101 drives it high.
- R8: Command 110 selects the echo edge. D11=1 sets `dout_rise` to 1. D11..D10=00 sets it to 0. D11..D10=01 leaves it unchanged.
- R9: Command 111 sets `pd_state` and pulses `shdn_req`. Both code registers keep their values, and words received during power-down are still carried out.
- R10: Command 000 changes no output register.
- R11: When `cs_n` falls, `dout` presents bit 15 of the last 16 bits shifted in. Each following bit is launched on the falling `sclk` edge when `dout_rise`=0, or on the rising edge when `dout_rise`=1. Zeros follow after bit 0.
- R12: `dout_oe` is 1 only while `cs_n` is low. While it stays 0, `dout` does not change.
- R13: `shdn_req` and `wake_req` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| cs_n | input | 1 | Active-low word select (asynchronous) |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial echo data |
| dout_oe | output | 1 | Output enable for `dout` (drive when 1) |
| in_code | output | 12 | Staging code register |
| dac_code | output | 12 | Converter code register |
| user_out | output | 1 | General-purpose logic output |
| dout_rise | output | 1 | Echo launch edge: 1 rising, 0 falling |
| pd_state | output | 1 | Power-down state flag |
| shdn_req | output | 1 | One-cycle power-down entry request |
| wake_req | output | 1 | One-cycle power-down exit request |

## Verification
On every cycle, the assertions check these points:
- `dac_code` never changes without a wake pulse.
- `in_code` changes only in the cycle after an accepted word.
- `pd_state` rises only with a shutdown request.
- The two request pulses are one cycle wide and never overlap.
- `dout` stays quiet while its enable is low.

Only the directed scenarios can show the remaining behaviour: the command semantics, the exact-length rule for 16-bit words, the sub-opcode decoding of the edge-select command, and the bit-exact echo order and launch edge in each mode.

// File: rtl/sdac_pkg.sv
// Shared constants and types for the serial DAC command interface.
// Assumes a fixed word of command, data and one trailing sub-bit.
package sdac_pkg;
    localparam int CMD_W      = 3;
    localparam int DATA_W     = 12;
    localparam int FRAME_BITS = CMD_W + DATA_W + 1;
    localparam int BODY_W     = CMD_W + DATA_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 3'b000,
        CMD_LOAD_IN   = 3'b001,
        CMD_UPDATE    = 3'b010,
        CMD_LOAD_BOTH = 3'b011,
        CMD_UO_LOW    = 3'b100,
        CMD_UO_HIGH   = 3'b101,
        CMD_ECHO_EDGE = 3'b110,
        CMD_SHDN      = 3'b111
    } cmd_e;

    // Word body without the sub-bit, MSB first on the wire
    typedef struct packed {
        cmd_e              cmd;
        logic [DATA_W-1:0] data;
    } body_t;
endpackage

// File: rtl/sdac_sync.sv
// Multi-bit synchronizer: each bit gets its own flop chain.
// Assumes STAGES >= 2 and that the inputs are independent slow levels.
module sdac_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the metastability chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d[i]};
        end

        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/sdac_shifter.sv
// Serial receive path: edge detection on the synchronized pins, the
// input shift register, the bit counter, the word-accept strobe and
// the echo shifter that drives dout.
// Assumes sclk and cs_n arrive already synchronized and that each
// sclk phase spans several system clocks.
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              din_s,
    input  logic              echo_rise,
    output logic [BODY_W-1:0] body,
    output logic              frame_go,
    output logic              dout,
    output logic              dout_oe
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_TOP = FRAME_BITS + 1;

    logic                  sclk_d;
    logic                  csn_d;
    logic [FRAME_BITS-1:0] sr;
    logic [FRAME_BITS-1:0] echo;
    logic [CNT_W-1:0]      cnt;
    logic                  sel_low;
    logic                  sclk_up;
    logic                  sclk_dn;
    logic                  cs_open;
    logic                  cs_close;
    logic                  echo_step;

    assign sel_low   = ~csn_s;
    assign sclk_up   = sclk_s & ~sclk_d & sel_low;
    assign sclk_dn   = ~sclk_s & sclk_d & sel_low;
    assign cs_open   = ~csn_s & csn_d;
    assign cs_close  = csn_s & ~csn_d;
    assign echo_step = echo_rise ? sclk_up : sclk_dn;
    assign body      = sr[FRAME_BITS-1 -: BODY_W];

    // Previous-sample registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    // Capture one bit per rising sclk while selected
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (sclk_up) sr <= {sr[FRAME_BITS-2:0], din_s};
    end

    // Count the bits of the current word, saturating past full length
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (cs_open)                    cnt <= '0;
        else if (sclk_up && cnt != CNT_TOP[CNT_W-1:0]) cnt <= cnt + 1'b1;
    end

    // Accept strobe: select released after exactly one full word
    always_ff @(posedge clk) begin
        if (!rst_n) frame_go <= 1'b0;
        else        frame_go <= cs_close && (cnt == FRAME_BITS[CNT_W-1:0]);
    end

    // Echo shifter: load the last word at select, step on the chosen edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo <= '0;
            dout <= 1'b0;
        end else if (cs_open) begin
            echo <= sr;
            dout <= sr[FRAME_BITS-1];
        end else if (echo_step) begin
            echo <= {echo[FRAME_BITS-2:0], 1'b0};
            dout <= echo[FRAME_BITS-2];
        end
    end

    // Output enable follows the synchronized select
    always_ff @(posedge clk) begin
        if (!rst_n) dout_oe <= 1'b0;
        else        dout_oe <= sel_low;
    end
endmodule

// File: rtl/sdac_exec.sv
// Command executor: decodes an accepted word and updates the two code
// registers, the user output, the echo edge flag and the power state.
// Assumes frame_go is a one-cycle strobe with body stable alongside.
module sdac_exec
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic [BODY_W-1:0] body,
    output logic [DATA_W-1:0] in_code,
    output logic [DATA_W-1:0] dac_code,
    output logic              user_out,
    output logic              echo_rise,
    output logic              pd_state,
    output logic              shdn_req,
    output logic              wake_req
);
    body_t w;
    assign w = body_t'(body);

    // Execute the decoded command and emit single-cycle requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_code   <= '0;
            dac_code  <= '0;
            user_out  <= 1'b0;
            echo_rise <= 1'b0;
            pd_state  <= 1'b0;
            shdn_req  <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            shdn_req <= 1'b0;
            wake_req <= 1'b0;
            if (frame_go) begin
                case (w.cmd)
                    CMD_LOAD_IN: in_code <= w.data;
                    CMD_UPDATE: begin
                        dac_code <= in_code;
                        pd_state <= 1'b0;
                        wake_req <= 1'b1;
                    end
                    CMD_LOAD_BOTH: begin
                        in_code  <= w.data;
                        dac_code <= w.data;
                        pd_state <= 1'b0;
                        wake_req <= 1'b1;
                    end
                    CMD_UO_LOW:  user_out <= 1'b0;
                    CMD_UO_HIGH: user_out <= 1'b1;
                    CMD_ECHO_EDGE: begin
                        if (w.data[DATA_W-1])                     echo_rise <= 1'b1;
                        else if (!w.data[DATA_W-2])               echo_rise <= 1'b0;
                    end
                    CMD_SHDN: begin
                        pd_state <= 1'b1;
                        shdn_req <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdac_cmd_if.sv
// Top level of the serial DAC command interface: synchronizes the
// serial pins, receives words and executes commands.
// Assumes sclk phases of several clk cycles and a quiet sclk around
// the cs_n edges.
module sdac_cmd_if
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic [DATA_W-1:0] in_code,
    output logic [DATA_W-1:0] dac_code,
    output logic              user_out,
    output logic              dout_rise,
    output logic              pd_state,
    output logic              shdn_req,
    output logic              wake_req
);
    logic [2:0]        pins_s;
    logic [BODY_W-1:0] body;
    logic              frame_go;

    sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({din, cs_n, sclk}),
        .q     (pins_s)
    );

    sdac_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .csn_s     (pins_s[1]),
        .din_s     (pins_s[2]),
        .echo_rise (dout_rise),
        .body      (body),
        .frame_go  (frame_go),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    sdac_exec u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_go  (frame_go),
        .body      (body),
        .in_code   (in_code),
        .dac_code  (dac_code),
        .user_out  (user_out),
        .echo_rise (dout_rise),
        .pd_state  (pd_state),
        .shdn_req  (shdn_req),
        .wake_req  (wake_req)
    );
endmodule

// File: rtl/sdac_cmd_chk.sv
// Assertion checker for sdac_cmd_if, attached by bind.
module sdac_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_go,
    input logic [11:0] in_code,
    input logic [11:0] dac_code,
    input logic        pd_state,
    input logic        shdn_req,
    input logic        wake_req,
    input logic        dout,
    input logic        dout_oe
);
    // R5
    dac_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> wake_req);

    // R3
    in_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_code) |-> $past(frame_go));

    // R9
    pd_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_state) |-> shdn_req);

    // R13
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shdn_req && wake_req));

    // R13
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R13
    shdn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> !shdn_req);

    // R12
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dout_oe && $past(!dout_oe)) |-> $stable(dout));
endmodule

bind sdac_cmd_if sdac_cmd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .in_code  (in_code),
    .dac_code (dac_code),
    .pd_state (pd_state),
    .shdn_req (shdn_req),
    .wake_req (wake_req),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/sdac_cmd_if_bench.sv
// Directed bench for sdac_cmd_if: one task per scenario.
module sdac_cmd_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout, dout_oe, user_out, dout_rise, pd_state, shdn_req, wake_req;
    logic [11:0] in_code, dac_code;

    int n_chk = 0;
    int n_bad = 0;
    int wake_cnt = 0;
    int shdn_cnt = 0;
    logic        done = 1'b0;
    logic [15:0] last16 = '0;
    logic [15:0] echo_exp;
    logic        lo_s [0:31];
    logic        hi_s [0:31];

    sdac_cmd_if u_sdac_cmd_if (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .in_code(in_code), .dac_code(dac_code),
        .user_out(user_out), .dout_rise(dout_rise), .pd_state(pd_state),
        .shdn_req(shdn_req), .wake_req(wake_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n && wake_req) wake_cnt <= wake_cnt + 1;
        if (rst_n && shdn_req) shdn_cnt <= shdn_cnt + 1;
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Shift n bits (MSB first) with cs_n low, sampling dout per phase
    task automatic send_bits(input logic [31:0] bits, input int n);
        echo_exp = last16;
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            wclk(4);
            din = bits[n-1-i];
            wclk(4);
            lo_s[i] = dout;
            sclk = 1'b1;
            last16 = {last16[14:0], bits[n-1-i]};
            wclk(8);
            hi_s[i] = dout;
        end
        sclk = 1'b0;
        wclk(8);
        cs_n = 1'b1;
        wclk(12);
    endtask

    task automatic word(input logic [2:0] cmd, input logic [11:0] data);
        send_bits({15'd0, cmd, data, 1'b0}, 16);
    endtask

    task automatic t_reset;
        chk("R1 in_code", in_code, 0);
        chk("R1 dac_code", dac_code, 0);
        chk("R1 flags", {user_out, dout_rise, pd_state, dout_oe, shdn_req, wake_req}, 0);
    endtask

    task automatic t_load_input;
        word(3'b001, 12'hA5C);
        chk("R4 in_code", in_code, 12'hA5C);
        chk("R4 dac_code kept", dac_code, 0);
        chk("R2 bit order", in_code[11], 1'b1);
    endtask

    task automatic t_update;
        int w0 = wake_cnt;
        word(3'b010, 12'h000);
        chk("R5 dac_code", dac_code, 12'hA5C);
        chk("R5 wake pulses", wake_cnt - w0, 1);
        chk("R13 no shdn", shdn_req, 0);
    endtask

    task automatic t_load_both;
        int w0 = wake_cnt;
        word(3'b011, 12'h3C1);
        chk("R6 in_code", in_code, 12'h3C1);
        chk("R6 dac_code", dac_code, 12'h3C1);
        chk("R6 wake pulses", wake_cnt - w0, 1);
    endtask

    task automatic t_user_out;
        word(3'b101, 12'h000);
        chk("R7 high", user_out, 1);
        word(3'b100, 12'hFFF);
        chk("R7 low", user_out, 0);
    endtask

    task automatic t_nop;
        word(3'b000, 12'hFFF);
        chk("R10 state", {in_code, dac_code, user_out, dout_rise, pd_state}, {12'h3C1, 12'h3C1, 3'b000});
    endtask

    task automatic t_bad_length;
        send_bits({17'd0, 3'b001, 12'h777}, 15);
        chk("R3 short ignored", in_code, 12'h3C1);
        send_bits({15'd0, 1'b0, 3'b001, 12'h777, 1'b0}, 17);
        chk("R3 long ignored", in_code, 12'h3C1);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; wclk(6); sclk = 1'b0; wclk(6);
        end
        word(3'b001, 12'h124);
        chk("R3 idle edges not counted", in_code, 12'h124);
    endtask

    task automatic t_echo_mode;
        word(3'b110, 12'h800);
        chk("R8 D11=1 rising", dout_rise, 1);
        word(3'b110, 12'h400);
        chk("R8 01 keeps mode", dout_rise, 1);
        word(3'b110, 12'h3FF);
        chk("R8 00 falling", dout_rise, 0);
    endtask

    task automatic t_echo_data;
        logic [15:0] e;
        int bad;
        word(3'b000, 12'h9B3);
        word(3'b000, 12'h000);
        e = echo_exp;
        bad = 0;
        for (int i = 0; i < 16; i++)
            if (lo_s[i] !== e[15-i] || hi_s[i] !== e[15-i]) bad++;
        chk("R11 falling-mode echo bits", bad, 0);
        word(3'b110, 12'hC00);
        word(3'b000, 12'h555);
        e = echo_exp;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (lo_s[i] !== e[15-i]) bad++;
            if (hi_s[i] !== ((i < 15) ? e[14-i] : 1'b0)) bad++;
        end
        chk("R11 rising-mode echo bits", bad, 0);
        word(3'b110, 12'h000);
    endtask

    task automatic t_oe;
        chk("R12 oe idle", dout_oe, 0);
        cs_n = 1'b0;
        wclk(8);
        chk("R12 oe selected", dout_oe, 1);
        cs_n = 1'b1;
        wclk(8);
        chk("R12 oe released", dout_oe, 0);
    endtask

    task automatic t_shutdown;
        int s0 = shdn_cnt;
        int w0 = wake_cnt;
        word(3'b111, 12'h000);
        chk("R9 pd_state", pd_state, 1);
        chk("R9 shdn pulses", shdn_cnt - s0, 1);
        chk("R9 codes kept", {in_code, dac_code}, {12'h124, 12'h3C1});
        word(3'b001, 12'hDEF);
        chk("R9 serial active", in_code, 12'hDEF);
        chk("R9 still down", pd_state, 1);
        word(3'b010, 12'h000);
        chk("R5 exits shutdown", {pd_state, dac_code}, {1'b0, 12'hDEF});
        chk("R5 wake once", wake_cnt - w0, 1);
        word(3'b111, 12'h000);
        word(3'b011, 12'h0F0);
        chk("R6 exits shutdown", {pd_state, dac_code}, {1'b0, 12'h0F0});
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_load_input();
        t_update();
        t_load_both();
        t_user_out();
        t_nop();
        t_bad_length();
        t_echo_mode();
        t_echo_data();
        t_oe();
        t_shutdown();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule